// File: doc/BRIEF.md
# PCIe Glue Client Register Block

This block is the small register file that sits beside a PCIe controller core. Software reaches it through an APB slave port. It holds the bits that pick the controller's role and release link training, a hot-reset control word, and the legacy INTx interrupt status and mask. It also publishes the live link-training state as a read-only word. Every writable word uses a split-half write. The upper 16 bits of the write data are per-bit enables for the lower 16 bits, so one bit can be changed without reading the word first.

The four INTx request lines from the core are sampled once per clock into the status word. A line raises the single level interrupt output only while its mask bit is clear. After reset all four lines are masked, so no interrupt reaches the system until software unmasks a line on purpose.

Top module: `pgr_client_regs`

## Requirements
- R1: After reset the general control word and the hot-reset control word read 0x00000000, the INTx mask word reads 0x0000000F, and irq_o, rc_mode_o, ltssm_en_o and enh_mode_o are 0.
- R2: A write to a writable word changes lower bit i (0..15) to pwdata[i] only when pwdata[i+16] is 1. Otherwise bit i keeps its old value. Without a write to it, the word does not change.
- R3: The general control word is at byte offset 0x000. rc_mode_o follows its bit 6. ltssm_en_o is 1 exactly when bits 3 and 2 are both 1. gen_ctrl_o shows the whole 16-bit word.
- R4: The hot-reset control word is at byte offset 0x180. enh_mode_o follows its bit 4. hot_ctrl_o shows the whole 16-bit word.
- R5: Reads of the general control, hot-reset, INTx status and INTx mask words return 0 in bits 31:16.
- R6: The INTx status word at byte offset 0x008 reads, in bits 3:0, the value of intx_req (bit 0 = line A to bit 3 = line D) sampled on the previous rising clock edge. Bits 15:4 read 0.
- R7: The INTx mask word at byte offset 0x01C stores 4 bits (bits 3:0, 1 = masked). Bits 15:4 read 0 even after a write that sets their enables.
- R8: irq_o is 1 exactly when some line n has sampled status bit n = 1 and mask bit n = 0. It follows a change of intx_req one clock later, and a change of the mask on the edge that commits the write.
- R9: The link status word at byte offset 0x300 reads ltssm_state in bits 5:0, phy_link_up in bit 16 and dl_link_up in bit 17, and 0 in every other bit.
- R10: Reads of any other byte address, misaligned ones included, return 0. Writes there, and writes to offsets 0x008 and 0x300, change no stored word.
- R11: pready is always 1 and pslverr is always 0, so every access takes exactly two cycles.
- R12: A write takes effect only in the access phase (psel, penable and pwrite all 1). A setup phase that is not followed by an access phase changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data; upper half holds the bit enables |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, tied high |
| pslverr | output | 1 | APB error, tied low |
| intx_req | input | N_INTX | Level INTx requests from the core |
| ltssm_state | input | LTSSM_W | Current link-training state |
| phy_link_up | input | 1 | Physical-layer link-up flag |
| dl_link_up | input | 1 | Data-link-layer link-up flag |
| gen_ctrl_o | output | 16 | General control word |
| hot_ctrl_o | output | 16 | Hot-reset control word |
| rc_mode_o | output | 1 | Root-complex mode selected |
| ltssm_en_o | output | 1 | Link training enabled |
| enh_mode_o | output | 1 | Enhanced training-enable control mode |
| irq_o | output | 1 | Combined legacy interrupt, level |

## Verification
The hardest case to reach is the full interaction of request levels and mask state. A line can be pending while masked, and then it must appear only in the status word and not on the interrupt. Reaching it needs each of the 16 mask values written in turn, with each of the 16 request patterns held at every mask value. The bench sweeps all 256 pairs and checks both irq_o and the status read-back for each pair. The split-half write is driven by a long run of pseudo-random enable/value pairs, so partial updates appear in every bit position against a bench model.

// File: rtl/pgr_pkg.sv
package pgr_pkg;

    localparam int unsigned OFF_GEN   = 32'h000;
    localparam int unsigned OFF_ISTAT = 32'h008;
    localparam int unsigned OFF_IMASK = 32'h01C;
    localparam int unsigned OFF_HOT   = 32'h180;
    localparam int unsigned OFF_LSTAT = 32'h300;

    localparam int unsigned HALF_W = 16;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_GEN,
        SEL_ISTAT,
        SEL_IMASK,
        SEL_HOT,
        SEL_LSTAT
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e sel;
        logic     wr_stb;
        logic     rd_stb;
    } apb_dec_t;

endpackage

// File: rtl/pgr_apb_decode.sv
module pgr_apb_decode
    import pgr_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output apb_dec_t          dec
);

    always_comb begin
        dec.sel    = SEL_NONE;
        dec.wr_stb = psel & penable & pwrite;
        dec.rd_stb = psel & penable & ~pwrite;
        case (paddr)
            ADDR_W'(OFF_GEN):   dec.sel = SEL_GEN;
            ADDR_W'(OFF_ISTAT): dec.sel = SEL_ISTAT;
            ADDR_W'(OFF_IMASK): dec.sel = SEL_IMASK;
            ADDR_W'(OFF_HOT):   dec.sel = SEL_HOT;
            ADDR_W'(OFF_LSTAT): dec.sel = SEL_LSTAT;
            default:            dec.sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/pgr_hiword_reg.sv
module pgr_hiword_reg #(
    parameter int unsigned        WIDTH = 16,
    parameter logic [WIDTH-1:0]   RST   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_val,
    input  logic [WIDTH-1:0] wr_bit_en,
    output logic [WIDTH-1:0] q
);

    typedef struct packed {
        logic [WIDTH-1:0] val;
    } hw_state_t;

    hw_state_t st_d, st_q;
    logic [WIDTH-1:0] merged;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign merged[i] = wr_bit_en[i] ? wr_val[i] : st_q.val[i];
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.val = merged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.val <= RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.val;

endmodule

// File: rtl/pgr_intx_gate.sv
module pgr_intx_gate #(
    parameter int unsigned N_INTX = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_INTX-1:0] req,
    input  logic [N_INTX-1:0] mask,
    output logic [N_INTX-1:0] status,
    output logic              irq
);

    typedef struct packed {
        logic [N_INTX-1:0] lvl;
    } gate_state_t;

    gate_state_t st_d, st_q;
    logic [N_INTX-1:0] pending;

    always_comb begin
        st_d     = st_q;
        st_d.lvl = req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lvl <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar n = 0; n < N_INTX; n++) begin : g_line
        assign pending[n] = st_q.lvl[n] & ~mask[n];
    end

    assign status = st_q.lvl;
    assign irq    = |pending;

endmodule

// File: rtl/pgr_client_regs.sv
module pgr_client_regs
    import pgr_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned N_INTX  = 4,
    parameter int unsigned LTSSM_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [31:0]        pwdata,
    output logic [31:0]        prdata,
    output logic               pready,
    output logic               pslverr,
    input  logic [N_INTX-1:0]  intx_req,
    input  logic [LTSSM_W-1:0] ltssm_state,
    input  logic               phy_link_up,
    input  logic               dl_link_up,
    output logic [15:0]        gen_ctrl_o,
    output logic [15:0]        hot_ctrl_o,
    output logic               rc_mode_o,
    output logic               ltssm_en_o,
    output logic               enh_mode_o,
    output logic               irq_o
);

    localparam int unsigned RC_BIT   = 6;
    localparam int unsigned LT_BIT_A = 2;
    localparam int unsigned LT_BIT_B = 3;
    localparam int unsigned ENH_BIT  = 4;

    apb_dec_t          dec;
    logic [N_INTX-1:0] mask_q;
    logic [N_INTX-1:0] status;

    pgr_apb_decode #(.ADDR_W(ADDR_W)) u_dec (
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .dec     (dec)
    );

    pgr_hiword_reg #(.WIDTH(HALF_W), .RST('0)) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (dec.wr_stb && dec.sel == SEL_GEN),
        .wr_val    (pwdata[HALF_W-1:0]),
        .wr_bit_en (pwdata[2*HALF_W-1:HALF_W]),
        .q         (gen_ctrl_o)
    );

    pgr_hiword_reg #(.WIDTH(HALF_W), .RST('0)) u_hot (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (dec.wr_stb && dec.sel == SEL_HOT),
        .wr_val    (pwdata[HALF_W-1:0]),
        .wr_bit_en (pwdata[2*HALF_W-1:HALF_W]),
        .q         (hot_ctrl_o)
    );

    pgr_hiword_reg #(.WIDTH(N_INTX), .RST('1)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (dec.wr_stb && dec.sel == SEL_IMASK),
        .wr_val    (pwdata[N_INTX-1:0]),
        .wr_bit_en (pwdata[HALF_W +: N_INTX]),
        .q         (mask_q)
    );

    pgr_intx_gate #(.N_INTX(N_INTX)) u_intx (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (intx_req),
        .mask   (mask_q),
        .status (status),
        .irq    (irq_o)
    );

    always_comb begin
        prdata = '0;
        unique case (dec.sel)
            SEL_GEN:   prdata[HALF_W-1:0] = gen_ctrl_o;
            SEL_HOT:   prdata[HALF_W-1:0] = hot_ctrl_o;
            SEL_IMASK: prdata[N_INTX-1:0] = mask_q;
            SEL_ISTAT: prdata[N_INTX-1:0] = status;
            SEL_LSTAT: begin
                prdata[LTSSM_W-1:0] = ltssm_state;
                prdata[16]          = phy_link_up;
                prdata[17]          = dl_link_up;
            end
            default:   prdata = '0;
        endcase
    end

    assign pready     = 1'b1;
    assign pslverr    = 1'b0;
    assign rc_mode_o  = gen_ctrl_o[RC_BIT];
    assign ltssm_en_o = gen_ctrl_o[LT_BIT_A] & gen_ctrl_o[LT_BIT_B];
    assign enh_mode_o = hot_ctrl_o[ENH_BIT];

endmodule

// File: rtl/pgr_client_regs_chk.sv
module pgr_client_regs_chk
    import pgr_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned N_INTX = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [31:0]       pwdata,
    input logic [31:0]       prdata,
    input logic              pready,
    input logic              pslverr,
    input logic [N_INTX-1:0] intx_req,
    input logic [15:0]       gen_ctrl_o,
    input logic [15:0]       hot_ctrl_o,
    input logic              rc_mode_o,
    input logic              irq_o
);

    logic acc_wr, acc_rd, at_gen, at_hot, mapped, zero_hi;

    assign acc_wr  = psel & penable & pwrite;
    assign acc_rd  = psel & penable & ~pwrite;
    assign at_gen  = (paddr == ADDR_W'(OFF_GEN));
    assign at_hot  = (paddr == ADDR_W'(OFF_HOT));
    assign zero_hi = at_gen | at_hot | (paddr == ADDR_W'(OFF_IMASK)) |
                     (paddr == ADDR_W'(OFF_ISTAT));
    assign mapped  = zero_hi | (paddr == ADDR_W'(OFF_LSTAT));

    assert_apb_ok_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pready && !pslverr);

    assert_gen_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_wr && at_gen) |=> $stable(gen_ctrl_o));

    assert_hot_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_wr && at_hot) |=> $stable(hot_ctrl_o));

    assert_gen_merge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && at_gen) |=> gen_ctrl_o ==
            (($past(gen_ctrl_o) & ~$past(pwdata[31:16])) |
             ($past(pwdata[15:0]) & $past(pwdata[31:16]))));

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && !mapped) |-> prdata == 32'h0);

    assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && zero_hi) |-> prdata[31:16] == 16'h0);

    assert_rc_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rc_mode_o) |-> $past(acc_wr && at_gen && pwdata[22] && pwdata[6]));

    assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (intx_req == '0) |=> !irq_o);

endmodule

bind pgr_client_regs pgr_client_regs_chk #(.ADDR_W(ADDR_W), .N_INTX(N_INTX)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .psel       (psel),
    .penable    (penable),
    .pwrite     (pwrite),
    .paddr      (paddr),
    .pwdata     (pwdata),
    .prdata     (prdata),
    .pready     (pready),
    .pslverr    (pslverr),
    .intx_req   (intx_req),
    .gen_ctrl_o (gen_ctrl_o),
    .hot_ctrl_o (hot_ctrl_o),
    .rc_mode_o  (rc_mode_o),
    .irq_o      (irq_o)
);

// File: tb/tb_pgr_client_regs.sv
module tb_pgr_client_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic [3:0]  intx_req = '0;
    logic [5:0]  ltssm_state = '0;
    logic        phy_link_up = 1'b0, dl_link_up = 1'b0;
    logic [15:0] gen_ctrl_o, hot_ctrl_o;
    logic        rc_mode_o, ltssm_en_o, enh_mode_o, irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    logic [15:0] gen_m = '0, hot_m = '0;
    logic [3:0]  mask_m = 4'hF;

    always #2.5 clk = ~clk;

    pgr_client_regs dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .intx_req(intx_req), .ltssm_state(ltssm_state),
        .phy_link_up(phy_link_up), .dl_link_up(dl_link_up),
        .gen_ctrl_o(gen_ctrl_o), .hot_ctrl_o(hot_ctrl_o), .rc_mode_o(rc_mode_o),
        .ltssm_en_o(ltssm_en_o), .enh_mode_o(enh_mode_o), .irq_o(irq_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] merge16(input logic [15:0] old, input logic [31:0] d);
        return (old & ~d[31:16]) | (d[15:0] & d[31:16]);
    endfunction

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed;
    endfunction

    task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1;
        d = prdata;
        check(pready === 1'b1 && pslverr === 1'b0, "R11",
              {30'b0, pslverr, pready}, 32'h1);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic check_stored(input string req);
        logic [31:0] d;
        apb_rd(12'h000, d); check(d == {16'h0, gen_m}, req, d, {16'h0, gen_m});
        apb_rd(12'h180, d); check(d == {16'h0, hot_m}, req, d, {16'h0, hot_m});
        apb_rd(12'h01C, d); check(d == {28'h0, mask_m}, req, d, {28'h0, mask_m});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check_stored("R1");
        check({irq_o, rc_mode_o, ltssm_en_o, enh_mode_o} == 4'b0, "R1",
              {28'h0, irq_o, rc_mode_o, ltssm_en_o, enh_mode_o}, 32'h0);

        // R2 / R5 random split-half writes on both control words
        for (int k = 0; k < 96; k++) begin
            w = rnd();
            apb_wr(12'h000, w);
            gen_m = merge16(gen_m, w);
            check(gen_ctrl_o == gen_m, "R2", {16'h0, gen_ctrl_o}, {16'h0, gen_m});
            apb_rd(12'h000, d);
            check(d == {16'h0, gen_m}, "R5", d, {16'h0, gen_m});
            w = rnd();
            apb_wr(12'h180, w);
            hot_m = merge16(hot_m, w);
            check(hot_ctrl_o == hot_m, "R2", {16'h0, hot_ctrl_o}, {16'h0, hot_m});
            apb_rd(12'h180, d);
            check(d == {16'h0, hot_m}, "R5", d, {16'h0, hot_m});
        end

        // R3 role and training-enable decode
        apb_wr(12'h000, 32'hFFFF_0000); gen_m = 16'h0;
        apb_wr(12'h000, 32'h0040_0040); gen_m = 16'h0040;
        check(rc_mode_o == 1'b1 && ltssm_en_o == 1'b0, "R3",
              {30'h0, rc_mode_o, ltssm_en_o}, 32'h2);
        apb_wr(12'h000, 32'h000C_000C); gen_m = 16'h004C;
        check(rc_mode_o == 1'b1 && ltssm_en_o == 1'b1, "R3",
              {30'h0, rc_mode_o, ltssm_en_o}, 32'h3);
        apb_wr(12'h000, 32'h0008_0000); gen_m = 16'h0044;
        check(ltssm_en_o == 1'b0 && gen_ctrl_o == 16'h0044, "R3",
              {15'h0, ltssm_en_o, gen_ctrl_o}, 32'h0044);

        // R4 enhanced mode bit
        apb_wr(12'h180, 32'hFFFF_0010); hot_m = 16'h0010;
        check(enh_mode_o == 1'b1, "R4", {31'h0, enh_mode_o}, 32'h1);
        apb_wr(12'h180, 32'h0010_FFEF); hot_m = 16'h0000;
        check(enh_mode_o == 1'b0 && hot_ctrl_o == 16'h0, "R4",
              {15'h0, enh_mode_o, hot_ctrl_o}, 32'h0);

        // R6 R7 R8 exhaustive mask x request
        for (int m = 0; m < 16; m++) begin
            apb_wr(12'h01C, {16'hFFFF, 12'hFFF, 4'(m)});
            mask_m = 4'(m);
            apb_rd(12'h01C, d);
            check(d == {28'h0, mask_m}, "R7", d, {28'h0, mask_m});
            for (int r = 0; r < 16; r++) begin
                @(negedge clk);
                intx_req = 4'(r);
                @(negedge clk);
                check(irq_o == |(4'(r) & ~mask_m), "R8",
                      {31'h0, irq_o}, {31'h0, |(4'(r) & ~mask_m)});
                apb_rd(12'h008, d);
                check(d == {28'h0, 4'(r)}, "R6", d, {28'h0, 4'(r)});
            end
        end
        // R8 mask change acts on the commit edge
        intx_req = 4'h4;
        apb_wr(12'h01C, 32'h000F_000F); mask_m = 4'hF;
        check(irq_o == 1'b0, "R8", {31'h0, irq_o}, 32'h0);
        apb_wr(12'h01C, 32'h0004_0000); mask_m = 4'hB;
        check(irq_o == 1'b1, "R8", {31'h0, irq_o}, 32'h1);
        intx_req = 4'h0;
        @(negedge clk);
        check(irq_o == 1'b0, "R8", {31'h0, irq_o}, 32'h0);

        // R9 link status sweep
        for (int s = 0; s < 64; s++) begin
            ltssm_state = 6'(s);
            phy_link_up = s[0];
            dl_link_up  = s[1] ^ s[3];
            apb_rd(12'h300, d);
            w = {14'h0, dl_link_up, phy_link_up, 10'h0, 6'(s)};
            check(d == w, "R9", d, w);
        end

        // R10 unmapped and read-only offsets
        foreach (d[i]) begin end
        for (int a = 0; a < 8; a++) begin
            logic [11:0] ua;
            case (a)
                0: ua = 12'h004; 1: ua = 12'h001; 2: ua = 12'h008; 3: ua = 12'h300;
                4: ua = 12'h3FC; 5: ua = 12'h181; 6: ua = 12'h01D; default: ua = 12'hFFF;
            endcase
            apb_wr(ua, 32'hFFFF_FFFF);
            check_stored("R10");
            if (ua != 12'h008 && ua != 12'h300) begin
                apb_rd(ua, d);
                check(d == 32'h0, "R10", d, 32'h0);
            end
        end

        // R12 setup phase without access phase
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = 12'h000; pwdata = 32'hFFFF_FFFF;
        @(negedge clk);
        psel = 1'b0; pwrite = 1'b0;
        @(negedge clk);
        check(gen_ctrl_o == gen_m, "R12", {16'h0, gen_ctrl_o}, {16'h0, gen_m});
        check_stored("R12");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule